// File: doc/BRIEF.md
# Decoded One-Hot Byte Population Counter

This block counts the set bits in one byte using three flat levels of logic. There is no adder chain. Each half of the byte goes to its own decoder, and both decoders are the same circuit. Each decoder raises exactly one of five lines, and that line says whether its four bits hold zero, one, two, three or four ones. A sum-of-products stage then pairs every upper-half line with every lower-half line. It ORs together the pairs whose counts add up to the same total, which gives a one-hot total vector. An encoder turns that vector into a binary count.

The path is purely combinational. It has no clock, no reset and no storage, so it can sit inside a larger cycle next to other logic. The one-hot total vector is brought out as a port so that the layers around the block, or a checker, can observe it. The all-ones byte has its own total line. That line drives an `all_ones` flag and the top bit of a four-bit count, so a full byte reads as eight and does not wrap to zero. The data pins are plain levels with no handshake, because nothing in the block holds data.

Top module: `byte_onehot_popcount`

## Requirements
- R1: For every value of `data_in`, `count` equals the number of 1 bits in `data_in`, as an unsigned 4-bit binary number.
- R2: For n from 1 to 8, `onehot[n]` is 1 exactly when `data_in` holds n set bits. Port bit index n stands for total n.
- R3: At most one bit of `onehot[8:1]` is 1 for any input, and all of them are 0 exactly when `data_in` is 0x00.
- R4: Input 0x00 gives `count` = 4'b0000, `onehot` = 8'h00 and `all_ones` = 0.
- R5: Input 0xFF gives `count` = 4'b1000, `onehot` = 8'h80 (only bit 8) and `all_ones` = 1.
- R6: `all_ones` is 1 for input 0xFF only, and 0 for every other input.
- R7: The count bits follow from the total lines. `count[0]` is the OR of onehot bits 1, 3, 5 and 7. `count[1]` is the OR of bits 2, 3, 6 and 7. `count[2]` is the OR of bits 4, 5, 6 and 7. `count[3]` equals bit 8.
- R8: The two nibbles are treated the same way: swapping bits 7:4 with bits 3:0 of the input leaves `count` and `onehot` unchanged.
- R9: The outputs follow a change of `data_in` within the same time step, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | 8 | Byte whose set bits are counted |
| count | output | 4 | Binary number of set bits, 0 to 8 |
| all_ones | output | 1 | High when every input bit is 1 |
| onehot | output | 8 | One-hot total vector, index [8:1], bit n high for total n |

## Verification
The checker's immediate assertions assume that `data_in` holds only known 0/1 values whenever the combinational logic re-evaluates. An unknown bit would make the one-hot and encoding checks meaningless. The bench therefore drives only fully specified byte values. It changes them on the falling edge of its pacing clock and samples the outputs a short time later. Every check therefore sees settled, known inputs and never a partly updated vector.

// File: rtl/popcount_pkg.sv
package popcount_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int TOT_N  = BYTE_W;
  localparam int CNT_W  = $clog2(TOT_N + 1);

  // number of ones in a constant pattern, used to place decoder minterms
  function automatic int ones_in(input int pattern);
    int acc;
    acc = 0;
    for (int b = 0; b < 32; b++) acc += (pattern >> b) & 1;
    return acc;
  endfunction
endpackage

// File: rtl/nibble_count_decoder.sv
module nibble_count_decoder
  import popcount_pkg::*;
#(
  parameter int W = NIB_W
) (
  input  logic [W-1:0] nib,
  output logic [W:0]   level
);
  localparam int PATTERNS = 1 << W;

  // sum of minterms: each input pattern raises the line of its own weight
  always_comb begin
    level = '0;
    for (int p = 0; p < PATTERNS; p++) begin
      if (nib == W'(p)) level[ones_in(p)] = 1'b1;
    end
  end
endmodule

// File: rtl/onehot_sum_combiner.sv
module onehot_sum_combiner
  import popcount_pkg::*;
#(
  parameter int W = NIB_W
) (
  input  logic [W:0]   hi_lvl,
  input  logic [W:0]   lo_lvl,
  output logic [2*W:1] total
);
  // total line n collects every pair (i, j) with i + j = n
  always_comb begin
    total = '0;
    for (int i = 0; i <= W; i++) begin
      for (int j = 0; j <= W; j++) begin
        if (i + j >= 1) total[i + j] = total[i + j] | (hi_lvl[i] & lo_lvl[j]);
      end
    end
  end
endmodule

// File: rtl/onehot_bin_encoder.sv
module onehot_bin_encoder
  import popcount_pkg::*;
#(
  parameter int N   = TOT_N,
  parameter int O_W = $clog2(N + 1)
) (
  input  logic [N:1]     oh,
  output logic [O_W-1:0] bin
);
  // each output bit ORs the lines whose index has that bit set
  always_comb begin
    bin = '0;
    for (int n = 1; n <= N; n++) begin
      for (int b = 0; b < O_W; b++) begin
        if (((n >> b) & 1) != 0) bin[b] = bin[b] | oh[n];
      end
    end
  end
endmodule

// File: rtl/byte_onehot_popcount.sv
module byte_onehot_popcount
  import popcount_pkg::*;
(
  input  logic [BYTE_W-1:0] data_in,
  output logic [CNT_W-1:0]  count,
  output logic              all_ones,
  output logic [TOT_N:1]    onehot
);
  logic [NIB_W:0] upper_lvl;
  logic [NIB_W:0] lower_lvl;

  nibble_count_decoder #(.W(NIB_W)) i_dec_upper (
    .nib   (data_in[BYTE_W-1:NIB_W]),
    .level (upper_lvl)
  );

  nibble_count_decoder #(.W(NIB_W)) i_dec_lower (
    .nib   (data_in[NIB_W-1:0]),
    .level (lower_lvl)
  );

  onehot_sum_combiner #(.W(NIB_W)) i_combine (
    .hi_lvl (upper_lvl),
    .lo_lvl (lower_lvl),
    .total  (onehot)
  );

  onehot_bin_encoder #(.N(TOT_N), .O_W(CNT_W)) i_encode (
    .oh  (onehot),
    .bin (count)
  );

  assign all_ones = onehot[TOT_N];
endmodule

// File: rtl/popcount_checker.sv
module popcount_checker
  import popcount_pkg::*;
(
  input logic [BYTE_W-1:0] data_in,
  input logic [CNT_W-1:0]  count,
  input logic              all_ones,
  input logic [TOT_N:1]    onehot
);
  always_comb begin
    a_r1_count_is_popcount: assert (int'(count) == $countones(data_in))
      else $error("R1: count %0d for input %02h", count, data_in);
    a_r3_total_onehot0: assert ($onehot0(onehot))
      else $error("R3: total vector %b not one-hot", onehot);
    a_r3_zero_iff_empty: assert ((onehot == '0) == (data_in == '0))
      else $error("R3: zero total mismatch for input %02h", data_in);
    a_r6_flag_only_full: assert (all_ones == (data_in == '1))
      else $error("R6: all_ones %b for input %02h", all_ones, data_in);
    a_r7_bit0_from_lines: assert (count[0] == (onehot[1] | onehot[3] | onehot[5] | onehot[7]))
      else $error("R7: count bit 0 disagrees with total lines");
    a_r7_bit3_from_line8: assert (count[3] == onehot[8])
      else $error("R7: count bit 3 disagrees with line 8");
  end
endmodule

bind byte_onehot_popcount popcount_checker i_popcount_checker (
  .data_in  (data_in),
  .count    (count),
  .all_ones (all_ones),
  .onehot   (onehot)
);

// File: tb/test_byte_onehot_popcount.sv
`timescale 1ns/1ps
module test_byte_onehot_popcount;
  logic       clk = 1'b0;
  logic [7:0] data_in = 8'h00;
  logic [3:0] count;
  logic       all_ones;
  logic [8:1] onehot;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  byte_onehot_popcount i_byte_onehot_popcount (
    .data_in  (data_in),
    .count    (count),
    .all_ones (all_ones),
    .onehot   (onehot)
  );

  function automatic int ref_ones(input logic [7:0] v);
    int acc = 0;
    for (int b = 0; b < 8; b++) acc += int'(v[b]);
    return acc;
  endfunction

  function automatic logic [8:1] ref_vec(input logic [7:0] v);
    logic [8:1] r = '0;
    if (ref_ones(v) > 0) r[ref_ones(v)] = 1'b1;
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp, input logic [7:0] v);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s input=%02h actual=%0d expected=%0d", req, v, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] v);
    @(negedge clk);
    data_in = v;
    #2;
  endtask

  task automatic t_zero_input();
    apply(8'h00);
    check("R4 count", int'(count), 0, 8'h00);
    check("R4 onehot", int'(onehot), 0, 8'h00);
    check("R4 all_ones", int'(all_ones), 0, 8'h00);
  endtask

  task automatic t_full_byte();
    apply(8'hFF);
    check("R5 count", int'(count), 8, 8'hFF);
    check("R5 onehot", int'(onehot), 'h80, 8'hFF);
    check("R5 all_ones", int'(all_ones), 1, 8'hFF);
  endtask

  task automatic t_single_bits();
    for (int b = 0; b < 8; b++) begin
      apply(8'(1 << b));
      check("R2 single bit", int'(onehot), 1, data_in);
      check("R1 single bit", int'(count), 1, data_in);
    end
  endtask

  task automatic t_exhaustive();
    for (int v = 0; v < 256; v++) begin
      apply(8'(v));
      check("R1 count", int'(count), ref_ones(8'(v)), 8'(v));
      check("R2 onehot", int'(onehot), int'(ref_vec(8'(v))), 8'(v));
      check("R3 at most one", $countones(onehot), (v == 0) ? 0 : 1, 8'(v));
      check("R6 all_ones", int'(all_ones), (v == 255) ? 1 : 0, 8'(v));
      check("R7 bit1", int'(count[1]), int'(onehot[2] | onehot[3] | onehot[6] | onehot[7]), 8'(v));
      check("R7 bit2", int'(count[2]), int'(onehot[4] | onehot[5] | onehot[6] | onehot[7]), 8'(v));
    end
  endtask

  task automatic t_nibble_swap();
    logic [7:0] pats [6] = '{8'h1E, 8'h30, 8'hF1, 8'h07, 8'hC5, 8'h9F};
    for (int k = 0; k < 6; k++) begin
      logic [3:0] c_a;
      logic [8:1] o_a;
      apply(pats[k]);
      c_a = count;
      o_a = onehot;
      apply({pats[k][3:0], pats[k][7:4]});
      check("R8 swap count", int'(count), int'(c_a), data_in);
      check("R8 swap onehot", int'(onehot), int'(o_a), data_in);
    end
  endtask

  task automatic t_no_clock_needed();
    @(posedge clk);
    #3;
    data_in = 8'h77;
    #1;
    check("R9 settles without edge", int'(count), 6, 8'h77);
    data_in = 8'h01;
    #1;
    check("R9 settles without edge", int'(count), 1, 8'h01);
  endtask

  initial begin
    t_zero_input();
    t_full_byte();
    t_single_bits();
    t_exhaustive();
    t_nibble_swap();
    t_no_clock_needed();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule